// File: doc/BRIEF.md
# Device Protection Mode Controller

This block holds the security state of a microcontroller-class device. It has four protection modes: a transient boot mode, an open mode, a protected mode and a terminal kill mode. After reset it sits in boot mode and keeps the debug port stalled. It leaves boot mode once the stored protection setting has been read out of nonvolatile configuration and loaded. An unprogrammed or malformed stored word counts as open, which is the setting of a fresh device.

Once configured, the CPU may request a new mode through a simple write port. Only the one-way paths are honoured:

- open to protected;
- open to kill;
- protected back to open, and only after the flash controller has reported a completed full-chip erase while protected.

Every other request is dropped. The block drives registered permission outputs from the current mode:

- debug enable;
- debug stall;
- flash-erase permit;
- flash-program-through-debug permit;
- forced-privileged indication for the CPU.

Top module: `prot_mode_ctrl`

## Requirements
- R1: During and right after reset the mode is boot (code 00). The outputs show dbg_stall=1 and force_priv=1, and dbg_en, erase_ok and dbg_prog_ok are 0.
- R2: The mode stays boot until a cycle with nv_valid=1. Mode writes made in boot are ignored. Once boot has been left it is never entered again.
- R3: On the nv_valid cycle in boot, the mode becomes the low two bits of nv_word when the higher bits are zero and the low two bits are 01 (open), 10 (protected) or 11 (kill). Any other word loads open (01). nv_valid outside boot is ignored.
- R4: In open mode, dbg_en=1, dbg_prog_ok=1 and erase_ok=1, and dbg_stall=0 and force_priv=0.
- R5: A write (wr_en=1) of wr_mode=10 or 11 while in open moves the mode to protected or kill on the next clock edge.
- R6: In protected mode, dbg_en=0, dbg_prog_ok=0, erase_ok=1, dbg_stall=0 and force_priv=0.
- R7: A one-cycle erase_done pulse while protected arms the return path. A write of 01 moves protected to open only when armed. erase_done in any other mode arms nothing. Arming takes effect from the cycle after the pulse.
- R8: The arming is cleared when the protected-to-open transition is taken. A later protected-to-open request needs a new erase.
- R9: Kill mode is terminal. No write and no erase_done leaves it. In kill, erase_ok=0, dbg_en=0 and dbg_prog_ok=0.
- R10: All other write requests leave the mode unchanged. This covers any write of 00, protected to kill, a write of the current mode, and any write in kill.
- R11: mode_o changes on the clock edge that commits a transition. The permission outputs follow exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nv_valid | input | 1 | Stored configuration word is valid this cycle |
| nv_word | input | NV_W | Stored protection configuration word |
| wr_en | input | 1 | Mode write strobe from the CPU |
| wr_mode | input | 2 | Requested mode code |
| erase_done | input | 1 | One-cycle pulse: full flash erase completed |
| mode_o | output | 2 | Current mode code |
| dbg_en | output | 1 | Debug access to user code and memory allowed |
| dbg_stall | output | 1 | Debug port held stalled |
| erase_ok | output | 1 | Flash erase permitted |
| dbg_prog_ok | output | 1 | Flash programming through debug permitted |
| force_priv | output | 1 | CPU forced into privileged execution |

## Verification
A vector table starts from each configured mode (open, protected, kill, and an invalid stored word), with and without a preceding erase pulse, and applies every class of requested code. This separates the accepted one-way steps from the rejected ones and shows that an erase opens exactly one door. Directed sequences check three orderings. An erase taken in open must not arm a later protected state. The arming must be used up by one return to open. A stored word with stray upper bits must decode to open rather than to its low bits. A separate cycle-by-cycle check observes mode_o and dbg_en across one committed write, which shows the one-clock lag of the permission outputs.

// File: rtl/prot_mode_pkg.sv
package prot_mode_pkg;

  typedef enum logic [1:0] {
    PM_BOOT = 2'b00,
    PM_OPEN = 2'b01,
    PM_PROT = 2'b10,
    PM_KILL = 2'b11
  } pmode_e;

  typedef struct packed {
    logic dbg_en;
    logic dbg_stall;
    logic erase_ok;
    logic prog_ok;
    logic force_priv;
  } perm_t;

  // Whether a requested step from cur to req may be committed.
  function automatic logic step_allowed(input pmode_e cur, input pmode_e req,
                                        input logic armed);
    logic ok;
    ok = 1'b0;
    case (cur)
      PM_OPEN: ok = (req == PM_PROT) || (req == PM_KILL);
      PM_PROT: ok = (req == PM_OPEN) && armed;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Permission set granted by a mode.
  function automatic perm_t perms_of(input pmode_e m);
    perm_t p;
    p.dbg_en     = (m == PM_OPEN);
    p.dbg_stall  = (m == PM_BOOT);
    p.erase_ok   = (m == PM_OPEN) || (m == PM_PROT);
    p.prog_ok    = (m == PM_OPEN);
    p.force_priv = (m == PM_BOOT);
    return p;
  endfunction

endpackage

// File: rtl/prot_nv_loader.sv
module prot_nv_loader
  import prot_mode_pkg::*;
#(
  parameter int NV_W = 8
) (
  input  logic            nv_valid,
  input  logic [NV_W-1:0] nv_word,
  input  logic            in_boot,
  output logic            load_fire,
  output pmode_e          load_mode
);

  localparam int CODE_W = 2;

  // Anything but a clean open/protected/kill code decodes to open.
  function automatic pmode_e decode_nv(input logic [NV_W-1:0] w);
    logic [NV_W-1:0] hi;
    logic [1:0]      lo;
    hi = w >> CODE_W;
    lo = w[CODE_W-1:0];
    if (hi != '0 || lo == 2'b00) return PM_OPEN;
    return pmode_e'(lo);
  endfunction

  assign load_fire = nv_valid && in_boot;
  assign load_mode = decode_nv(nv_word);

  always_comb begin
    assert (load_mode != PM_BOOT) else $error("AST_NV_NEVER_BOOT"); // R3
  end

endmodule

// File: rtl/prot_erase_arm.sv
module prot_erase_arm
  import prot_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   erase_done,
  input  pmode_e mode_i,
  input  logic   to_open,
  output logic   armed_o,
  output logic   arm_set
);

  logic armed_q;

  assign arm_set = erase_done && (mode_i == PM_PROT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (to_open) armed_q <= 1'b0;
    else if (arm_set) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  AST_ARM_ONLY_IN_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (mode_i == PM_PROT)) else $error("AST_ARM_ONLY_IN_PROT"); // R7

  AST_ARM_USED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (to_open && !arm_set) |=> !armed_q) else $error("AST_ARM_USED_ONCE"); // R8

endmodule

// File: rtl/prot_mode_fsm.sv
module prot_mode_fsm
  import prot_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_fire,
  input  pmode_e     load_mode,
  input  logic       wr_en,
  input  logic [1:0] wr_mode,
  input  logic       armed_i,
  output pmode_e     mode_o,
  output logic       wr_accept,
  output logic       to_open
);

  pmode_e mode_q, mode_d;
  pmode_e req;

  assign req       = pmode_e'(wr_mode);
  assign wr_accept = wr_en && step_allowed(mode_q, req, armed_i);
  assign to_open   = wr_accept && (mode_q == PM_PROT);

  always_comb begin
    mode_d = mode_q;
    if (mode_q == PM_BOOT) begin
      if (load_fire) mode_d = load_mode;
    end else if (wr_accept) begin
      mode_d = req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_BOOT;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_KILL_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_KILL) |=> (mode_q == PM_KILL)) else $error("AST_KILL_TERMINAL"); // R9

  AST_NO_BOOT_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PM_BOOT) |=> (mode_q != PM_BOOT)) else $error("AST_NO_BOOT_REENTRY"); // R2

  AST_BOOT_WAITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_BOOT && !load_fire) |=> (mode_q == PM_BOOT)) else $error("AST_BOOT_WAITS_LOAD"); // R2

  AST_PROT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_PROT && !armed_i) |=> (mode_q == PM_PROT)) else $error("AST_PROT_NEEDS_ARM"); // R7

  AST_NO_PROT_TO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_PROT) |=> (mode_q != PM_KILL)) else $error("AST_NO_PROT_TO_KILL"); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PM_BOOT && !wr_en) |=> $stable(mode_q)) else $error("AST_IDLE_HOLDS"); // R10

endmodule

// File: rtl/prot_perm_reg.sv
module prot_perm_reg
  import prot_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  pmode_e mode_i,
  output perm_t  perm_o
);

  perm_t perm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) perm_q <= perms_of(PM_BOOT);
    else        perm_q <= perms_of(mode_i);
  end

  assign perm_o = perm_q;

  AST_STALL_EXCLUDES_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q.dbg_stall |-> !perm_q.dbg_en) else $error("AST_STALL_EXCLUDES_DEBUG"); // R1

  AST_KILL_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PM_KILL) |=> !perm_q.erase_ok) else $error("AST_KILL_NO_ERASE"); // R9

  AST_PROG_NEEDS_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q.prog_ok |-> perm_q.dbg_en) else $error("AST_PROG_NEEDS_DEBUG"); // R4

endmodule

// File: rtl/prot_mode_ctrl.sv
module prot_mode_ctrl
  import prot_mode_pkg::*;
#(
  parameter int NV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nv_valid,
  input  logic [NV_W-1:0] nv_word,
  input  logic            wr_en,
  input  logic [1:0]      wr_mode,
  input  logic            erase_done,
  output logic [1:0]      mode_o,
  output logic            dbg_en,
  output logic            dbg_stall,
  output logic            erase_ok,
  output logic            dbg_prog_ok,
  output logic            force_priv
);

  // Named internal events
  logic   load_fire;
  pmode_e load_mode;
  pmode_e mode_cur;
  logic   armed;
  logic   arm_set;
  logic   wr_accept;
  logic   to_open;
  perm_t  perm;

  prot_nv_loader #(.NV_W(NV_W)) u_loader (
    .nv_valid  (nv_valid),
    .nv_word   (nv_word),
    .in_boot   (mode_cur == PM_BOOT),
    .load_fire (load_fire),
    .load_mode (load_mode)
  );

  prot_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_fire (load_fire),
    .load_mode (load_mode),
    .wr_en     (wr_en),
    .wr_mode   (wr_mode),
    .armed_i   (armed),
    .mode_o    (mode_cur),
    .wr_accept (wr_accept),
    .to_open   (to_open)
  );

  prot_erase_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .erase_done (erase_done),
    .mode_i     (mode_cur),
    .to_open    (to_open),
    .armed_o    (armed),
    .arm_set    (arm_set)
  );

  prot_perm_reg u_perm (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_cur),
    .perm_o (perm)
  );

  assign mode_o      = mode_cur;
  assign dbg_en      = perm.dbg_en;
  assign dbg_stall   = perm.dbg_stall;
  assign erase_ok    = perm.erase_ok;
  assign dbg_prog_ok = perm.prog_ok;
  assign force_priv  = perm.force_priv;

  AST_ACCEPT_NOT_IN_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> (mode_cur != PM_BOOT)) else $error("AST_ACCEPT_NOT_IN_BOOT"); // R2

  AST_ARM_NEVER_IN_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == PM_KILL) |-> !arm_set) else $error("AST_ARM_NEVER_IN_KILL"); // R9

endmodule

// File: tb/prot_mode_ctrl_test.sv
`timescale 1ns/1ps
module prot_mode_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nv_valid = 1'b0;
  logic [7:0] nv_word = 8'h00;
  logic       wr_en = 1'b0;
  logic [1:0] wr_mode = 2'b00;
  logic       erase_done = 1'b0;
  logic [1:0] mode_o;
  logic       dbg_en, dbg_stall, erase_ok, dbg_prog_ok, force_priv;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  prot_mode_ctrl #(.NV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .nv_valid(nv_valid), .nv_word(nv_word),
    .wr_en(wr_en), .wr_mode(wr_mode), .erase_done(erase_done),
    .mode_o(mode_o), .dbg_en(dbg_en), .dbg_stall(dbg_stall),
    .erase_ok(erase_ok), .dbg_prog_ok(dbg_prog_ok), .force_priv(force_priv)
  );

  // {nv_word[7:0], erase, req[1:0], expected mode[1:0]}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {8'h01, 1'b0, 2'b10, 2'b10},
    {8'h01, 1'b0, 2'b11, 2'b11},
    {8'h01, 1'b0, 2'b00, 2'b01},
    {8'h01, 1'b0, 2'b01, 2'b01},
    {8'h02, 1'b0, 2'b01, 2'b10},
    {8'h02, 1'b1, 2'b01, 2'b01},
    {8'h02, 1'b1, 2'b11, 2'b10},
    {8'h02, 1'b0, 2'b00, 2'b10},
    {8'h03, 1'b1, 2'b01, 2'b11},
    {8'h03, 1'b0, 2'b10, 2'b11},
    {8'h03, 1'b0, 2'b00, 2'b11},
    {8'hFF, 1'b0, 2'b10, 2'b10}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Checks all five permission outputs as one packed word
  task automatic check_perm(input string tag, input logic [4:0] exp);
    check(tag, {3'b0, dbg_en, dbg_stall, erase_ok, dbg_prog_ok, force_priv}, {3'b0, exp});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; nv_valid = 1'b0; wr_en = 1'b0; erase_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic nv_load(input logic [7:0] w);
    nv_word = w; nv_valid = 1'b1;
    @(negedge clk);
    nv_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] m);
    wr_mode = m; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic erase_pulse();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // Reset state: {dbg_en, dbg_stall, erase_ok, prog_ok, force_priv}
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 mode during reset", {6'b0, mode_o}, 8'h00);
    check_perm("R1 perms during reset", 5'b01001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode after reset", {6'b0, mode_o}, 8'h00);
    check_perm("R1 perms after reset", 5'b01001);

    // R2: boot persists, writes ignored
    wr(2'b10);
    repeat (4) @(negedge clk);
    check("R2 boot holds under write", {6'b0, mode_o}, 8'h00);
    check("R2 stall held", {7'b0, dbg_stall}, 8'h01);

    // Vector walk over transitions
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      do_reset();
      nv_load(v[12:5]);
      if (v[4]) erase_pulse();
      wr(v[3:2]);
      check($sformatf("R5/R7/R9/R10 vector %0d", i), {6'b0, mode_o}, {6'b0, v[1:0]});
    end

    // R3: decode corner cases
    do_reset(); nv_load(8'h00);
    check("R3 zero word to open", {6'b0, mode_o}, 8'h01);
    do_reset(); nv_load(8'h12);
    check("R3 stray upper bits to open", {6'b0, mode_o}, 8'h01);
    nv_load(8'h03);
    check("R3 reload after boot ignored", {6'b0, mode_o}, 8'h01);

    // R4 open perms
    check_perm("R4 open perms", 5'b10110);

    // R11 latency of perms
    wr_mode = 2'b10; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 mode moves at edge", {6'b0, mode_o}, 8'h02);
    check("R11 dbg_en still old", {7'b0, dbg_en}, 8'h01);
    @(negedge clk);
    check("R11 dbg_en one clock later", {7'b0, dbg_en}, 8'h00);
    check_perm("R6 protected perms", 5'b00100);

    // R7: erase taken in open does not arm a later protected state
    do_reset(); nv_load(8'h01);
    erase_pulse();
    wr(2'b10);
    wr(2'b01);
    check("R7 open-erase does not arm", {6'b0, mode_o}, 8'h02);

    // R8: arming used up by one return
    erase_pulse();
    wr(2'b01);
    check("R8 armed return to open", {6'b0, mode_o}, 8'h01);
    wr(2'b10);
    wr(2'b01);
    check("R8 second return needs new erase", {6'b0, mode_o}, 8'h02);

    // R9 kill perms and erase immunity
    do_reset(); nv_load(8'h03);
    erase_pulse();
    wr(2'b01);
    check("R9 kill stays", {6'b0, mode_o}, 8'h03);
    check_perm("R9 kill perms", 5'b00000);

    // R10: write of protected while protected keeps mode
    do_reset(); nv_load(8'h02);
    wr(2'b10);
    check("R10 same-mode write", {6'b0, mode_o}, 8'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule